// File: doc/BRIEF.md
# Embedded-Clock Serial Frame Decoder

This block takes a serial bit stream that has already been sampled, one bit per fast clock, and turns it back into 24-bit pixel words. Every 28-bit frame is bracketed by two fixed clock bits. The decoder uses those bits to find the frame boundary by itself, with no preamble, training pattern or sync word. It then undoes the per-frame inversion that the sender applies for DC balance, checks the frame against its parity bit, and presents the payload in parallel.

The decoder starts by searching for a bit alignment where frames keep showing a 1 at the start and a 0 at the end. It commits to that alignment once enough frames agree. While committed, it tolerates short bursts of corrupted clock bits. A longer burst sends it back to searching. Downstream logic sees a word, a one-cycle strobe, a parity error flag that comes with that strobe, and a level that says whether the alignment is trusted.

Top module: `ecframe_decoder`

## Requirements
- R1: A frame is 28 bits. In order of arrival it holds: a clock bit that is 1, payload bits 0 to 11, the parity bit, the invert bit, payload bits 12 to 23, and a clock bit that is 0. Payload bit i appears on `pixel_data[i]`, and `pixel_data` keeps its value until the next frame is delivered.
- R2: When the invert bit of a frame is 1, all 24 received payload bits are complemented before output. When it is 0, they pass through unchanged.
- R3: The parity bit is chosen so that the count of ones across the 24 transmitted payload bits, the invert bit and the parity bit is even. When a delivered frame breaks this rule, `frame_error` is high in the same cycle as its `pixel_valid`, and its data is still delivered. Otherwise `frame_error` stays low.
- R4: Lock is declared by the 8th consecutive frame that shows correct clock bits at one alignment, and that frame is delivered. When frames start right after reset, the 7th frame leaves `link_locked` low and is not delivered.
- R5: Lock is reached on arbitrary payload from any starting bit offset. Each failed boundary check moves the search to the next bit alignment.
- R6: While locked, up to 3 consecutive frames with a wrong clock bit keep the lock, and those frames are still delivered. A frame with correct clock bits restarts that count.
- R7: The 4th consecutive frame with a wrong clock bit drops `link_locked` and is not delivered. The search then restarts and lock is regained on a clean stream.
- R8: `pixel_valid` lasts one cycle, is high only while `link_locked` is high, and repeats every 28 cycles while lock holds. It rises on the clock edge after the edge that samples the frame's last bit.
- R9: A synchronous active-high reset clears `link_locked`, `pixel_valid`, `frame_error`, `pixel_data` and the alignment search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Sampled serial bit |
| pixel_data | output | 24 | Restored payload of the last delivered frame |
| pixel_valid | output | 1 | One-cycle strobe per delivered frame |
| link_locked | output | 1 | Frame alignment is trusted |
| frame_error | output | 1 | Parity mismatch on the frame delivered this cycle |

## Verification
Lock acquisition and the parity check can land on the same frame. The frame that completes the eighth agreement is delivered in the same cycle that `link_locked` rises, so a parity fault on it must show up together with the new lock. The bench provokes this by sending seven clean frames after reset and an eighth with a flipped parity bit. It then requires `pixel_valid`, `link_locked` and `frame_error` to be high in one sample, with the payload correctly restored.

// File: rtl/ecf_pkg.sv
package ecf_pkg;

  typedef enum logic {
    ECF_HUNT  = 1'b0,
    ECF_TRACK = 1'b1
  } ecf_mode_e;

  // A boundary is credible when the leading clock bit is high and the
  // trailing clock bit is low.
  function automatic logic clock_bits_ok(input logic lead, input logic trail);
    return lead & ~trail;
  endfunction

endpackage

// File: rtl/ecf_window.sv
module ecf_window #(
  parameter int FRAME_LEN = 28
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_in,
  input  logic                 hold,
  output logic [FRAME_LEN-1:0] frame,
  output logic                 at_edge
);
  localparam int CW = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

  logic [CW-1:0] pos_q;

  // Newest bit enters at index 0, so the first bit of a frame ends at the top.
  always_ff @(posedge clk) begin
    if (rst) begin
      frame <= '0;
      pos_q <= '0;
    end else begin
      frame <= {frame[FRAME_LEN-2:0], bit_in};
      if (!hold) begin
        pos_q <= (pos_q == LAST) ? '0 : pos_q + CW'(1);
      end
    end
  end

  assign at_edge = (pos_q == LAST);

  // R5
  slip_only_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    hold |-> at_edge);

  // R5
  slip_rechecks_next_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> at_edge);

  // R8
  edge_not_repeated_chk: assert property (@(posedge clk) disable iff (rst)
    (at_edge && !hold) |=> !at_edge);

endmodule

// File: rtl/ecf_lock_fsm.sv
module ecf_lock_fsm
  import ecf_pkg::*;
#(
  parameter int LOCK_FRAMES   = 8,
  parameter int UNLOCK_MISSES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic at_edge,
  input  logic clk_ok,
  output logic hold,
  output logic locked,
  output logic lock_next,
  output logic gain_ev,
  output logic drop_ev
);
  localparam int AW = $clog2(LOCK_FRAMES + 1);
  localparam int MW = $clog2(UNLOCK_MISSES + 1);
  localparam logic [AW-1:0] AGREE_LAST = AW'(LOCK_FRAMES - 1);
  localparam logic [MW-1:0] MISS_LAST  = MW'(UNLOCK_MISSES - 1);

  ecf_mode_e     mode_q;
  logic [AW-1:0] agree_q;
  logic [MW-1:0] miss_q;
  logic          pass_ev;
  logic          fail_ev;

  assign pass_ev   = at_edge && clk_ok;
  assign fail_ev   = at_edge && !clk_ok;
  assign gain_ev   = (mode_q == ECF_HUNT)  && pass_ev && (agree_q == AGREE_LAST);
  assign drop_ev   = (mode_q == ECF_TRACK) && fail_ev && (miss_q == MISS_LAST);
  assign hold      = ((mode_q == ECF_HUNT) && fail_ev) || drop_ev;
  assign locked    = (mode_q == ECF_TRACK);
  assign lock_next = ((mode_q == ECF_TRACK) && !drop_ev) || gain_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= ECF_HUNT;
      agree_q <= '0;
      miss_q  <= '0;
    end else if (mode_q == ECF_HUNT) begin
      if (fail_ev) begin
        agree_q <= '0;
      end else if (gain_ev) begin
        mode_q  <= ECF_TRACK;
        agree_q <= '0;
        miss_q  <= '0;
      end else if (pass_ev) begin
        agree_q <= agree_q + AW'(1);
      end
    end else begin
      if (pass_ev) begin
        miss_q <= '0;
      end else if (drop_ev) begin
        mode_q  <= ECF_HUNT;
        miss_q  <= '0;
        agree_q <= '0;
      end else if (fail_ev) begin
        miss_q <= miss_q + MW'(1);
      end
    end
  end

  // R4
  lock_rises_on_pass_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(at_edge && clk_ok));

  // R7
  lock_falls_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(at_edge && !clk_ok));

  // R6
  lock_kept_on_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && at_edge && clk_ok) |=> locked);

  // R6
  lock_kept_off_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && !at_edge) |=> locked);

endmodule

// File: rtl/ecf_unpack.sv
module ecf_unpack #(
  parameter int PAYLOAD_W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PAYLOAD_W+1:0]  body,
  input  logic                  deliver,
  output logic [PAYLOAD_W-1:0]  data,
  output logic                  valid,
  output logic                  err,
  output logic                  parity_bad
);
  localparam int BW   = PAYLOAD_W + 2;
  localparam int HALF = PAYLOAD_W / 2;
  localparam int PAR_IDX = BW - 1 - HALF;
  localparam int INV_IDX = BW - 2 - HALF;

  // Body is the frame without its clock bits; the first arrival sits at BW-1.
  function automatic logic [PAYLOAD_W-1:0] gather_payload(input logic [BW-1:0] b);
    logic [PAYLOAD_W-1:0] p;
    for (int i = 0; i < PAYLOAD_W; i++) begin
      if (i < HALF) p[i] = b[BW - 1 - i];
      else          p[i] = b[BW - 3 - i];
    end
    return p;
  endfunction

  function automatic logic odd_ones(input logic [PAYLOAD_W-1:0] p,
                                    input logic inv, input logic par);
    return ^{p, inv, par};
  endfunction

  function automatic logic [PAYLOAD_W-1:0] restore(input logic [PAYLOAD_W-1:0] p,
                                                   input logic inv);
    return p ^ {PAYLOAD_W{inv}};
  endfunction

  logic [PAYLOAD_W-1:0] wire_bits;
  logic                 inv_bit;
  logic                 par_bit;

  assign wire_bits  = gather_payload(body);
  assign inv_bit    = body[INV_IDX];
  assign par_bit    = body[PAR_IDX];
  assign parity_bad = odd_ones(wire_bits, inv_bit, par_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      valid <= 1'b0;
      err   <= 1'b0;
    end else begin
      valid <= deliver;
      err   <= deliver && parity_bad;
      if (deliver) data <= restore(wire_bits, inv_bit);
    end
  end

  // R8
  valid_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R3
  err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> valid);

  // R1
  data_held_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(data));

endmodule

// File: rtl/ecframe_decoder.sv
module ecframe_decoder
  import ecf_pkg::*;
#(
  parameter int PAYLOAD_W     = 24,
  parameter int LOCK_FRAMES   = 8,
  parameter int UNLOCK_MISSES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 serial_in,
  output logic [PAYLOAD_W-1:0] pixel_data,
  output logic                 pixel_valid,
  output logic                 link_locked,
  output logic                 frame_error
);
  localparam int FRAME_LEN = PAYLOAD_W + 4;

  logic [FRAME_LEN-1:0] frame;
  logic                 at_edge;
  logic                 hold;
  logic                 clk_ok;
  logic                 lock_next;
  logic                 gain_ev;
  logic                 drop_ev;
  logic                 deliver;
  logic                 parity_bad;

  ecf_window #(.FRAME_LEN(FRAME_LEN)) u_window (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (serial_in),
    .hold    (hold),
    .frame   (frame),
    .at_edge (at_edge)
  );

  assign clk_ok = clock_bits_ok(frame[FRAME_LEN-1], frame[0]);

  ecf_lock_fsm #(
    .LOCK_FRAMES   (LOCK_FRAMES),
    .UNLOCK_MISSES (UNLOCK_MISSES)
  ) u_lock (
    .clk       (clk),
    .rst       (rst),
    .at_edge   (at_edge),
    .clk_ok    (clk_ok),
    .hold      (hold),
    .locked    (link_locked),
    .lock_next (lock_next),
    .gain_ev   (gain_ev),
    .drop_ev   (drop_ev)
  );

  assign deliver = at_edge && lock_next;

  ecf_unpack #(.PAYLOAD_W(PAYLOAD_W)) u_unpack (
    .clk        (clk),
    .rst        (rst),
    .body       (frame[FRAME_LEN-2:1]),
    .deliver    (deliver),
    .data       (pixel_data),
    .valid      (pixel_valid),
    .err        (frame_error),
    .parity_bad (parity_bad)
  );

  // R8
  valid_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    pixel_valid |-> link_locked);

  // R7
  no_delivery_on_drop_chk: assert property (@(posedge clk) disable iff (rst)
    drop_ev |=> !pixel_valid);

  // R4
  delivery_on_gain_chk: assert property (@(posedge clk) disable iff (rst)
    gain_ev |=> (pixel_valid && link_locked));

endmodule

// File: tb/ecframe_decoder_test.sv
module ecframe_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        serial_in = 1'b0;
  logic [23:0] pixel_data;
  logic        pixel_valid;
  logic        link_locked;
  logic        frame_error;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [31:0] seed = 32'h2545F491;

  logic [23:0] prev_exp_data = '0;
  logic        prev_exp_err  = 1'b0;
  logic [23:0] obs_data, obs_exp_data;
  logic        obs_valid, obs_lock, obs_err, obs_exp_err;

  ecframe_decoder uut (
    .clk         (clk),
    .rst         (rst),
    .serial_in   (serial_in),
    .pixel_data  (pixel_data),
    .pixel_valid (pixel_valid),
    .link_locked (link_locked),
    .frame_error (frame_error)
  );

  always #4 clk = ~clk;

  function automatic logic [23:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[23:0];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    serial_in = b;
    @(negedge clk);
  endtask

  // Sends one frame; while doing so, records what the previous frame produced.
  task automatic send_frame(input logic [23:0] pix, input logic inv,
                            input logic bad_par, input logic bad_hi,
                            input logic bad_lo);
    logic [23:0] tx;
    logic        par;
    tx  = inv ? ~pix : pix;
    par = (^{tx, inv}) ^ bad_par;
    send_bit(~bad_hi);
    obs_valid    = pixel_valid;
    obs_data     = pixel_data;
    obs_err      = frame_error;
    obs_lock     = link_locked;
    obs_exp_data = prev_exp_data;
    obs_exp_err  = prev_exp_err;
    for (int i = 0; i < 12; i++) send_bit(tx[i]);
    send_bit(par);
    send_bit(inv);
    for (int i = 12; i < 24; i++) send_bit(tx[i]);
    send_bit(bad_lo);
    prev_exp_data = pix;
    prev_exp_err  = bad_par;
  endtask

  task automatic expect_prev(input string req, input logic want_valid);
    check(req, "pixel_valid", 32'(obs_valid), 32'(want_valid));
    check(req, "link_locked", 32'(obs_lock), 32'(want_valid));
    if (want_valid) begin
      check(req, "pixel_data", 32'(obs_data), 32'(obs_exp_data));
      check(req, "frame_error", 32'(obs_err), 32'(obs_exp_err));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    serial_in = 1'b0;
    prev_exp_data = '0;
    prev_exp_err  = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic relock(input string req);
    for (int n = 0; n < 90; n++) begin
      send_frame(next_rand(), seed[3], 1'b0, 1'b0, 1'b0);
      if (obs_lock) break;
    end
    check(req, "lock regained", 32'(obs_lock), 32'd1);
  endtask

  // R9: reset state, then reset out of a locked stream
  task automatic t_reset();
    do_reset();
    check("R9", "pixel_valid", 32'(pixel_valid), 32'd0);
    check("R9", "link_locked", 32'(link_locked), 32'd0);
    check("R9", "frame_error", 32'(frame_error), 32'd0);
    check("R9", "pixel_data", 32'(pixel_data), 32'd0);
  endtask

  task automatic t_midstream_reset();
    check("R9", "locked before reset", 32'(link_locked), 32'd1);
    do_reset();
    check("R9", "lock cleared", 32'(link_locked), 32'd0);
    check("R9", "data cleared", 32'(pixel_data), 32'd0);
    check("R9", "valid cleared", 32'(pixel_valid), 32'd0);
  endtask

  // R4: exact lock frame when frames begin right after reset
  task automatic t_lock_exact();
    do_reset();
    for (int k = 1; k <= 8; k++) send_frame(next_rand(), k[0], 1'b0, 1'b0, 1'b0);
    expect_prev("R4", 1'b0);
    send_frame(next_rand(), 1'b0, 1'b0, 1'b0, 1'b0);
    expect_prev("R4", 1'b1);
    send_frame(next_rand(), 1'b1, 1'b0, 1'b0, 1'b0);
    expect_prev("R8", 1'b1);
  endtask

  // R5: arbitrary starting offset
  task automatic t_offset(input int off);
    do_reset();
    for (int i = 0; i < off; i++) send_bit(seed[i % 32]);
    relock("R5");
    send_frame(next_rand(), 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(next_rand(), 1'b1, 1'b0, 1'b0, 1'b0);
    expect_prev("R5", 1'b1);
  endtask

  // R1 and R2: bit placement and inversion
  task automatic t_mapping();
    logic [23:0] pats [12];
    logic        invs [12];
    pats[0] = 24'h000001;  invs[0] = 1'b0;
    pats[1] = 24'h000800;  invs[1] = 1'b0;
    pats[2] = 24'h001000;  invs[2] = 1'b0;
    pats[3] = 24'h800000;  invs[3] = 1'b0;
    pats[4] = 24'hFFFFFF;  invs[4] = 1'b0;
    pats[5] = 24'h000001;  invs[5] = 1'b1;
    pats[6] = 24'h000800;  invs[6] = 1'b1;
    pats[7] = 24'h001000;  invs[7] = 1'b1;
    pats[8] = 24'h800000;  invs[8] = 1'b1;
    pats[9] = 24'h000000;  invs[9] = 1'b1;
    pats[10] = 24'hA5F00F; invs[10] = 1'b1;
    pats[11] = 24'h3C96E1; invs[11] = 1'b0;
    for (int j = 0; j <= 12; j++) begin
      if (j < 12) send_frame(pats[j], invs[j], 1'b0, 1'b0, 1'b0);
      else        send_frame(next_rand(), 1'b0, 1'b0, 1'b0, 1'b0);
      if (j > 0) expect_prev(invs[j-1] ? "R2" : "R1", 1'b1);
    end
  endtask

  // R3: parity faults, with and without inversion
  task automatic t_parity();
    send_frame(24'h123456, 1'b0, 1'b1, 1'b0, 1'b0);
    send_frame(24'h0F0F0F, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_prev("R3", 1'b1);
    send_frame(24'h7E7E00, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_prev("R3", 1'b1);
    send_frame(next_rand(), 1'b0, 1'b0, 1'b0, 1'b0);
    expect_prev("R3", 1'b1);
  endtask

  // R6 and R7: clock-bit faults while locked
  task automatic t_misses();
    // 1 = faulty frame, 0 = clean frame
    logic kinds [12] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0,
                         1'b1, 1'b1, 1'b1, 1'b1};
    for (int j = 0; j <= 12; j++) begin
      if (j < 12) send_frame(next_rand(), j[1], 1'b0, kinds[j] & j[0],
                             kinds[j] & ~j[0]);
      else        send_frame(next_rand(), 1'b0, 1'b0, 1'b0, 1'b0);
      if (j > 0 && j < 12) expect_prev("R6", 1'b1);
      if (j == 12) expect_prev("R7", 1'b0);
    end
    relock("R7");
  endtask

  // R3 with R4: parity fault on the frame that completes lock
  task automatic t_coincide();
    do_reset();
    for (int k = 1; k <= 7; k++) send_frame(next_rand(), 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(24'hC0FFEE, 1'b1, 1'b1, 1'b0, 1'b0);
    send_frame(next_rand(), 1'b0, 1'b0, 1'b0, 1'b0);
    check("R4", "lock with error", 32'(obs_lock), 32'd1);
    check("R3", "error on lock frame", 32'(obs_err), 32'd1);
    check("R3", "valid on lock frame", 32'(obs_valid), 32'd1);
    check("R2", "data on lock frame", 32'(obs_data), 32'hC0FFEE);
  endtask

  // R8 monitor: width, lock qualification and spacing of the strobe
  logic mon_last = 1'b0;
  bit   mon_armed = 1'b0;
  int   mon_gap = 0;
  always @(negedge clk) begin
    if (rst || finished) begin
      mon_last  <= 1'b0;
      mon_armed <= 1'b0;
      mon_gap   <= 0;
    end else begin
      if (pixel_valid) begin
        check("R8", "valid while locked", 32'(link_locked), 32'd1);
        check("R8", "valid width", 32'(mon_last), 32'd0);
        if (mon_armed) check("R8", "valid spacing", 32'(mon_gap + 1), 32'd28);
        mon_armed <= link_locked;
        mon_gap   <= 0;
      end else begin
        mon_gap <= mon_gap + 1;
        if (!link_locked) mon_armed <= 1'b0;
      end
      mon_last <= pixel_valid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lock_exact();
    t_mapping();
    t_parity();
    t_misses();
    t_midstream_reset();
    t_offset(3);
    t_offset(14);
    t_offset(27);
    t_coincide();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule